// File: doc/BRIEF.md
# Speculative Access Signature Tracker

This block records, for one speculatively running thread, which memory words it has read and which it has written. It keeps each set as a compact hashed bit vector (a signature), so that the tracking storage stays fixed in size however many addresses the thread touches. Every access arrives as a byte address with a read/write flag. The block hashes the address and ORs the resulting bit pattern into the read signature or the write signature.

When the thread commits, the block publishes its whole write signature as one wide word and empties both signatures. When another thread commits, its write signature is presented to this block. The block then intersects that signature with its own two signatures and, if they may overlap, raises a squash. The squash also empties both signatures, so that the thread can start again. Because many addresses share signature bits, the block can report a conflict where no true dependence exists; that is acceptable by design.

A combinational membership query reports whether a given address may be present in either signature.

Top module: `spec_sig_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, both signatures are empty, `squash` and `sig_out_valid` are 0, `sig_out` is all zeros, and both query outputs are 0.
- R2: An address is hashed from its word address `w = acc_addr[31:2]`. The two low byte-offset bits are ignored, so tracking is per word. The signature is 2048 bits in 8 segments of 256 bits. For segment s (0 to 7), the index is the low 8 bits of `w` rotated right by 3*s within its 30 bits, and the bit set is `s*256 + index`.
- R3: An access with `acc_is_wr`=0 sets its pattern only in the read signature, and one with `acc_is_wr`=1 only in the write signature. The effect is visible from the cycle after the access. Bits once set stay set until a clear.
- R4: `query_hit_rd` (or `query_hit_wr`) is 1 exactly when, in every segment, the read (or write) signature has the bit that `query_addr` hashes to. The outputs follow the current signatures combinationally.
- R5: In the cycle after `commit` is high, `sig_out_valid` is 1 for one cycle and `sig_out` equals the write signature as it stood in the commit cycle. `sig_out` then holds that value until the next commit.
- R6: In the cycle after `remote_valid` is high, `squash` is 1 exactly when `remote_sig` AND the read signature, or `remote_sig` AND the write signature, is nonzero in every one of the 8 segments. The comparison uses the signatures as they stood before that cycle's access was added.
- R7: A remote signature whose segments come from different local addresses still raises `squash`, even though no single address matches; such false conflicts are accepted.
- R8: A cycle with `commit` or `squash` high empties both signatures at its end. An access presented in that cycle is dropped.
- R9: With `remote_valid` low, `squash` is 0 in the next cycle, whatever `remote_sig` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A memory access is presented |
| acc_is_wr | input | 1 | 1 for a write access, 0 for a read |
| acc_addr | input | 32 | Byte address of the access |
| commit | input | 1 | Local thread commits this cycle |
| remote_valid | input | 1 | A committed signature from another thread is presented |
| remote_sig | input | 2048 | That thread's write signature |
| query_addr | input | 32 | Address for the membership query |
| query_hit_rd | output | 1 | Address may be in the read signature |
| query_hit_wr | output | 1 | Address may be in the write signature |
| squash | output | 1 | Conflict found; local signatures are emptied |
| sig_out_valid | output | 1 | One-cycle pulse after a commit |
| sig_out | output | 2048 | Published write signature |

## Verification
The hardest case to reach from the ports is a false conflict. It needs a remote signature that overlaps the local one in every segment while sharing no whole address with it. The bench builds such a signature directly by taking segments 0 to 3 from one written address's pattern and segments 4 to 7 from another's. A second hard case is a segment-wise miss that leaves only one segment disjoint. The bench covers it by zeroing one segment of an otherwise matching pattern. Collisions between commit, squash and a same-cycle access come from directed stimulus. A random phase then draws addresses from a small pool, so that real and aliased overlaps occur often, and compares every output against a behavioural model on each clock.

// File: rtl/spec_sig_pkg.sv
package spec_sig_pkg;
   // hash variant selector
   typedef enum int {
      HASH_SLICE = 0,
      HASH_FOLD  = 1
   } hash_mode_e;
endpackage

// File: rtl/sig_hash.sv
module sig_hash #(
   parameter int ADDR_W      = 32,
   parameter int OFS_W       = 2,
   parameter int NUM_SEG     = 8,
   parameter int SEG_IDX_W   = 8,
   parameter int ROT_STEP    = 3,
   parameter int HASH_MODE   = spec_sig_pkg::HASH_SLICE,
   localparam int SEG_BITS   = 1 << SEG_IDX_W,
   localparam int SIG_W      = NUM_SEG * SEG_BITS,
   localparam int WADDR_W    = ADDR_W - OFS_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SIG_W-1:0]  pattern
);
   logic [WADDR_W-1:0] waddr;
   logic [NUM_SEG-1:0][SEG_IDX_W-1:0] seg_idx;

   if (SEG_IDX_W > WADDR_W) begin : g_bad_idx
      $error("sig_hash: segment index wider than word address");
   end
   if (OFS_W < 0 || OFS_W >= ADDR_W) begin : g_bad_ofs
      $error("sig_hash: offset width out of range");
   end

   assign waddr = addr[ADDR_W-1:OFS_W];

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      localparam int SHIFT = (s * ROT_STEP) % WADDR_W;
      for (genvar b = 0; b < SEG_IDX_W; b++) begin : g_bit
         if (HASH_MODE == spec_sig_pkg::HASH_FOLD) begin : g_fold
            assign seg_idx[s][b] = waddr[(b + SHIFT) % WADDR_W]
                                 ^ waddr[(b + SEG_IDX_W + SHIFT) % WADDR_W];
         end else begin : g_slice
            assign seg_idx[s][b] = waddr[(b + SHIFT) % WADDR_W];
         end
      end
      assign pattern[s*SEG_BITS +: SEG_BITS] =
         {{(SEG_BITS-1){1'b0}}, 1'b1} << seg_idx[s];
   end
endmodule

// File: rtl/sig_overlap.sv
module sig_overlap #(
   parameter int NUM_SEG   = 8,
   parameter int SEG_IDX_W = 8,
   localparam int SEG_BITS = 1 << SEG_IDX_W,
   localparam int SIG_W    = NUM_SEG * SEG_BITS
) (
   input  logic [SIG_W-1:0] sig_a,
   input  logic [SIG_W-1:0] sig_b,
   output logic             all_seg_hit
);
   logic [NUM_SEG-1:0] seg_hit;

   if (NUM_SEG < 1) begin : g_bad_seg
      $error("sig_overlap: need at least one segment");
   end

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      assign seg_hit[s] = |(sig_a[s*SEG_BITS +: SEG_BITS] & sig_b[s*SEG_BITS +: SEG_BITS]);
   end

   assign all_seg_hit = &seg_hit;
endmodule

// File: rtl/sig_store.sv
module sig_store #(
   parameter int SIG_W = 2048
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             ins_en,
   input  logic [SIG_W-1:0] ins_pat,
   output logic [SIG_W-1:0] sig
);
   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         sig <= '0;
      end else if (ins_en) begin
         sig <= sig | ins_pat;
      end
   end

   p_insert_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !clear) |=> ((sig & $past(ins_pat)) == $past(ins_pat)));

   p_bits_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((sig | $past(sig)) == sig));

   p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (sig == '0));
endmodule

// File: rtl/spec_sig_tracker.sv
module spec_sig_tracker #(
   parameter int ADDR_W    = 32,
   parameter int OFS_W     = 2,
   parameter int NUM_SEG   = 8,
   parameter int SEG_IDX_W = 8,
   parameter int ROT_STEP  = 3,
   parameter int HASH_MODE = spec_sig_pkg::HASH_SLICE,
   localparam int SEG_BITS = 1 << SEG_IDX_W,
   localparam int SIG_W    = NUM_SEG * SEG_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_is_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              commit,
   input  logic              remote_valid,
   input  logic [SIG_W-1:0]  remote_sig,
   input  logic [ADDR_W-1:0] query_addr,
   output logic              query_hit_rd,
   output logic              query_hit_wr,
   output logic              squash,
   output logic              sig_out_valid,
   output logic [SIG_W-1:0]  sig_out
);
   localparam int NUM_SIG = 2;   // index 0 = read, 1 = write

   logic [SIG_W-1:0] acc_pat;
   logic [SIG_W-1:0] qry_pat;
   logic [SIG_W-1:0] sig_q [NUM_SIG];
   logic [NUM_SIG-1:0] remote_hit;
   logic [NUM_SIG-1:0] query_hit;
   logic clear_all;
   logic acc_take;

   if (ROT_STEP < 0) begin : g_bad_rot
      $error("spec_sig_tracker: rotation step must be non-negative");
   end

   sig_hash #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .NUM_SEG(NUM_SEG),
      .SEG_IDX_W(SEG_IDX_W), .ROT_STEP(ROT_STEP), .HASH_MODE(HASH_MODE)
   ) u_acc_hash (
      .addr(acc_addr), .pattern(acc_pat)
   );

   sig_hash #(
      .ADDR_W(ADDR_W), .OFS_W(OFS_W), .NUM_SEG(NUM_SEG),
      .SEG_IDX_W(SEG_IDX_W), .ROT_STEP(ROT_STEP), .HASH_MODE(HASH_MODE)
   ) u_qry_hash (
      .addr(query_addr), .pattern(qry_pat)
   );

   assign clear_all = commit | squash;
   assign acc_take  = acc_valid & ~clear_all;

   for (genvar k = 0; k < NUM_SIG; k++) begin : g_sig
      logic ins_en;
      assign ins_en = acc_take & (acc_is_wr == (k == 1));

      sig_store #(.SIG_W(SIG_W)) u_store (
         .clk(clk), .rst_n(rst_n), .clear(clear_all),
         .ins_en(ins_en), .ins_pat(acc_pat), .sig(sig_q[k])
      );

      sig_overlap #(.NUM_SEG(NUM_SEG), .SEG_IDX_W(SEG_IDX_W)) u_remote_cmp (
         .sig_a(remote_sig), .sig_b(sig_q[k]), .all_seg_hit(remote_hit[k])
      );

      sig_overlap #(.NUM_SEG(NUM_SEG), .SEG_IDX_W(SEG_IDX_W)) u_query_cmp (
         .sig_a(qry_pat), .sig_b(sig_q[k]), .all_seg_hit(query_hit[k])
      );
   end

   assign query_hit_rd = query_hit[0];
   assign query_hit_wr = query_hit[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         squash        <= 1'b0;
         sig_out_valid <= 1'b0;
         sig_out       <= '0;
      end else begin
         squash        <= remote_valid & (|remote_hit);
         sig_out_valid <= commit;
         if (commit) begin
            sig_out <= sig_q[1];
         end
      end
   end

   p_no_squash_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !remote_valid |=> !squash);

   p_commit_publish_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (sig_out_valid && sig_out == $past(sig_q[1])));

   p_out_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> (!sig_out_valid && $stable(sig_out)));

   p_squash_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      squash |=> (!query_hit_rd && !query_hit_wr));
endmodule

// File: tb/spec_sig_tracker_bench.sv
`timescale 1ns/100ps
module spec_sig_tracker_bench;
   localparam int SW = 2048;
   localparam int NS = 8;
   localparam int SB = 256;

   logic clk = 1'b0;
   logic rst_n;
   logic acc_valid, acc_is_wr, commit, remote_valid;
   logic [31:0] acc_addr, query_addr;
   logic [SW-1:0] remote_sig;
   logic query_hit_rd, query_hit_wr, squash, sig_out_valid;
   logic [SW-1:0] sig_out;

   int n_vec = 0;
   int n_bad = 0;
   int cyc_cnt = 0;
   bit done = 1'b0;

   // reference state
   logic [SW-1:0] m_rd, m_wr, m_out;
   logic m_sq, m_out_v;

   always #2.5 clk = ~clk;

   spec_sig_tracker u_spec_sig_tracker (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_wr(acc_is_wr),
      .acc_addr(acc_addr), .commit(commit), .remote_valid(remote_valid),
      .remote_sig(remote_sig), .query_addr(query_addr),
      .query_hit_rd(query_hit_rd), .query_hit_wr(query_hit_wr),
      .squash(squash), .sig_out_valid(sig_out_valid), .sig_out(sig_out)
   );

   function automatic int hidx(logic [31:0] a, int s);
      logic [59:0] dbl;
      logic [59:0] sh;
      int r;
      r   = (3 * s) % 30;
      dbl = {a[31:2], a[31:2]};
      sh  = dbl >> r;
      return int'(sh[7:0]);
   endfunction

   function automatic logic [SW-1:0] pat(logic [31:0] a);
      logic [SW-1:0] p;
      p = '0;
      for (int s = 0; s < NS; s++) p[s*SB + hidx(a, s)] = 1'b1;
      return p;
   endfunction

   function automatic bit every_seg(logic [SW-1:0] x, logic [SW-1:0] y);
      for (int s = 0; s < NS; s++) begin
         bit any;
         any = 1'b0;
         for (int k = 0; k < SB; k++)
            if (x[s*SB+k] && y[s*SB+k]) any = 1'b1;
         if (!any) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic bit may_hold(logic [SW-1:0] sg, logic [31:0] a);
      for (int s = 0; s < NS; s++)
         if (!sg[s*SB + hidx(a, s)]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic chk1(string req, logic act, logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chkw(string req, logic [SW-1:0] act, logic [SW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle();
      acc_valid = 1'b0; acc_is_wr = 1'b0; acc_addr = '0;
      commit = 1'b0; remote_valid = 1'b0; remote_sig = '0;
   endtask

   // one clock: query check, model update at the edge, registered-output check
   task automatic cyc();
      bit sq_n;
      #1;
      chk1("R4 query rd", query_hit_rd, may_hold(m_rd, query_addr));
      chk1("R4 query wr", query_hit_wr, may_hold(m_wr, query_addr));
      @(posedge clk);
      sq_n = remote_valid && (every_seg(remote_sig, m_rd) || every_seg(remote_sig, m_wr));
      m_out_v = commit;
      if (commit) m_out = m_wr;
      if (commit || m_sq) begin
         m_rd = '0; m_wr = '0;
      end else if (acc_valid) begin
         if (acc_is_wr) m_wr = m_wr | pat(acc_addr);
         else           m_rd = m_rd | pat(acc_addr);
      end
      m_sq = sq_n;
      @(negedge clk);
      chk1("R6 squash", squash, m_sq);
      chk1("R5 sig_out_valid", sig_out_valid, m_out_v);
      chkw("R5 sig_out", sig_out, m_out);
   endtask

   task automatic access(logic wr, logic [31:0] a);
      idle(); acc_valid = 1'b1; acc_is_wr = wr; acc_addr = a;
      cyc();
   endtask

   task automatic probe(string req, logic [31:0] a, logic exp_rd, logic exp_wr);
      query_addr = a;
      #1;
      chk1({req, " rd"}, query_hit_rd, exp_rd);
      chk1({req, " wr"}, query_hit_wr, exp_wr);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 100000) begin
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         finish_run();
      end
   end

   localparam logic [31:0] A = 32'h0000_1000;
   localparam logic [31:0] B = 32'h0004_2468;
   localparam logic [31:0] C = 32'h1234_5678;

   initial begin
      logic [SW-1:0] mix;
      logic [31:0] pool [8];
      rst_n = 1'b0; idle(); query_addr = A;
      m_rd = '0; m_wr = '0; m_out = '0; m_sq = 1'b0; m_out_v = 1'b0;
      repeat (3) @(negedge clk);
      // R1 during reset and just after
      chk1("R1 squash", squash, 1'b0);
      chk1("R1 sig_out_valid", sig_out_valid, 1'b0);
      chkw("R1 sig_out", sig_out, '0);
      rst_n = 1'b1;
      probe("R1 query", A, 1'b0, 1'b0);
      cyc();

      // R3: read goes only to the read signature
      access(1'b0, A);
      idle();
      probe("R3 read only", A, 1'b1, 1'b0);
      // R2: word granularity, byte offset ignored
      access(1'b1, B);
      idle();
      probe("R2 word gran", B + 32'd3, 1'b0, 1'b1);
      probe("R3 write only", B, 1'b0, 1'b1);

      // R9: matching signature without valid
      idle(); remote_sig = pat(A);
      cyc();
      chk1("R9 no squash", squash, 1'b0);

      // R6: one segment disjoint -> no squash
      idle(); remote_valid = 1'b1; remote_sig = pat(A);
      remote_sig[SB-1:0] = '0;
      cyc();
      chk1("R6 seg miss", squash, 1'b0);

      // R6: matching read signature -> squash
      idle(); remote_valid = 1'b1; remote_sig = pat(A);
      cyc();
      chk1("R6 match", squash, 1'b1);
      // R8: squash cycle, same-cycle access dropped
      access(1'b1, C);
      idle();
      probe("R8 squash clear A", A, 1'b0, 1'b0);
      probe("R8 squash drop C", C, 1'b0, 1'b0);
      chk1("R8 squash pulse", squash, 1'b0);

      // R5 and R8 on commit
      access(1'b1, A);
      access(1'b1, B);
      idle(); commit = 1'b1; acc_valid = 1'b1; acc_is_wr = 1'b1; acc_addr = C;
      cyc();
      chk1("R5 valid pulse", sig_out_valid, 1'b1);
      chkw("R5 published", sig_out, pat(A) | pat(B));
      idle();
      probe("R8 commit drop C", C, 1'b0, 1'b0);
      probe("R8 commit clear B", B, 1'b0, 1'b0);
      cyc();
      chk1("R5 pulse ends", sig_out_valid, 1'b0);
      chkw("R5 holds", sig_out, pat(A) | pat(B));

      // R7: false conflict from mixed segments
      access(1'b1, A);
      access(1'b1, B);
      mix = pat(A);
      mix[SW-1:SW/2] = pat(B) >> (SW/2);
      mix[SW-1:SW/2] = (pat(B)[SW-1:SW/2]);
      idle(); remote_valid = 1'b1; remote_sig = mix;
      cyc();
      chk1("R7 false conflict", squash, 1'b1);
      idle(); cyc();

      // random phase
      pool[0] = A; pool[1] = B; pool[2] = C; pool[3] = 32'h0000_1004;
      pool[4] = 32'hFFFF_FFFC; pool[5] = 32'h8000_0000; pool[6] = 32'h0004_2469;
      pool[7] = 32'h0003_0300;
      for (int i = 0; i < 600; i++) begin
         int r;
         idle();
         r = int'($urandom_range(0, 99));
         acc_valid  = (r < 70);
         acc_is_wr  = $urandom_range(0, 1) != 0;
         acc_addr   = pool[$urandom_range(0, 7)] | 32'($urandom_range(0, 3));
         commit     = ($urandom_range(0, 99) < 6);
         remote_valid = ($urandom_range(0, 99) < 15);
         remote_sig = pat(pool[$urandom_range(0, 7)]);
         if ($urandom_range(0, 1) != 0) remote_sig = remote_sig | pat(pool[$urandom_range(0, 7)]);
         query_addr = pool[$urandom_range(0, 7)];
         cyc();
      end
      idle();
      cyc();
      finish_run();
   end
endmodule